// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down on its own slow clock and raises a one-cycle reset pulse if software stops servicing it. All control goes through 16-bit key words written to a key register. One key starts the watchdog and another refreshes it. A third key opens the prescaler and reload registers for a single configuration pass. The counter is 12 bits wide by default and restarts from all ones. It is clocked by a power-of-two divider that the 3-bit prescaler code selects.

Configuration writes pass through a short update stage before they take effect. A busy flag for each register shows in the status register while that stage is in progress. A debug-halt input, together with a stop-enable input, can freeze counting while a debugger holds the processor. Once started, the watchdog can only be returned to idle by the synchronous system reset.

The whole block runs in the watchdog clock domain. Bus writes are taken as single-cycle strobes in that domain, and register reads are combinational.

Top module: `keywdt_top`

## Requirements
- R1: After reset (rst_n low, synchronous), the watchdog is idle and `wdt_rst` stays low. Reads return 0 for the prescaler (address 1), all ones for the reload value (address 2) and 0 for the status (address 3).
- R2: A write of 0xCCCC to the key register (address 0) starts an idle watchdog. The counter is loaded with all ones, and the first pulse follows (2^CNT_W)·D cycles after the write edge, where D is the tick divide ratio. A start key written while the watchdog is running changes no timing.
- R3: The prescaler code c (bits [2:0] at address 1) sets D = 2^(2+c) for c = 0..6. Code 7 also gives D = 256.
- R4: A write of 0xAAAA to the key register while running loads the counter with the active reload value R and restarts the divider, so the next pulse follows (R+1)·D cycles after that write. The refresh key has no effect while the watchdog is idle.
- R5: `wdt_rst` is high for exactly one cycle. The counter then restarts from all ones, so the next pulse follows (2^CNT_W)·D cycles later.
- R6: No key or register write stops a running watchdog; only rst_n returns it to idle.
- R7: A write to the prescaler register or to the reload register (bits [CNT_W-1:0] at address 2) is ignored unless the most recent key write was 0x5555.
- R8: Any key write other than 0x5555, the refresh key included, closes the configuration access again. Prescaler and reload writes do not close it.
- R9: In the status register, bit 0 marks a pending prescaler update and bit 1 a pending reload update. Each bit is high for SYNC_CYCLES cycles after an accepted write. The written value reads back at once, but it governs counting only once its bit clears.
- R10: While `dbg_halt` and `halt_stop_en` are both high, the counter and the divider hold their values. With `halt_stop_en` low, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog slow clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 prescaler, 2 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 1 prescaler, 2 reload, 3 status |
| rd_data | output | 16 | Combinational read data |
| dbg_halt | input | 1 | Processor held by a debugger |
| halt_stop_en | input | 1 | Freeze the counter while dbg_halt is high |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with a 6-bit counter and a 3-cycle update stage. At that size one full countdown takes at most 16,384 cycles, even at the largest divide ratio. This lets the bench sweep all eight prescaler codes and all 64 reload values, each time measuring the exact pulse distance against (R+1)·D. The small counter also puts repeated pulses, freeze intervals, lock/unlock sequences and the window in which an update is still pending within a few hundred cycles of each other.

// File: rtl/keywdt_pkg.sv
// Package: shared key codes and register addresses of the keyed watchdog.
// Assumes 16-bit key words and a 2-bit register address.
package keywdt_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [1:0] {
        REG_KEY    = 2'd0,
        REG_PRESC  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/keywdt_keyctl.sv
// Key decoder: turns key-register writes into start/refresh requests and
// tracks the configuration access state. Assumes one write per cycle.
module keywdt_keyctl
    import keywdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    output logic             start_req,
    output logic             refresh_req,
    output logic             cfg_open,
    output logic             presc_load,
    output logic             reload_load
);
    logic key_wr;

    // Decode write strobes per register.
    always_comb begin
        key_wr      = wr_en && (wr_addr == REG_KEY);
        start_req   = key_wr && (wr_data == KEY_START);
        refresh_req = key_wr && (wr_data == KEY_REFRESH);
        presc_load  = wr_en && (wr_addr == REG_PRESC) && cfg_open;
        reload_load = wr_en && (wr_addr == REG_RELOAD) && cfg_open;
    end

    // Access opens only on the unlock key; any other key closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_open <= 1'b0;
        end else if (key_wr) begin
            cfg_open <= (wr_data == KEY_UNLOCK);
        end
    end
endmodule

// File: rtl/keywdt_cfgsync.sv
// Configuration update stage: holds the written value and copies it to the
// active value after SYNC_CYCLES cycles; busy is high meanwhile.
// Assumes SYNC_CYCLES >= 1. A new write restarts the delay.
module keywdt_cfgsync #(
    parameter int          W           = 3,
    parameter int          SYNC_CYCLES = 3,
    parameter logic [W-1:0] RESET_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int SC_W = $clog2(SYNC_CYCLES + 1);

    logic [SC_W-1:0] wait_cnt;

    // Busy while the delay counter is non-zero.
    always_comb busy = (wait_cnt != '0);

    // Capture writes, count down the delay, then commit to the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow   <= RESET_VAL;
            active   <= RESET_VAL;
            wait_cnt <= '0;
        end else if (load) begin
            shadow   <= din;
            wait_cnt <= SC_W'(SYNC_CYCLES);
        end else if (busy) begin
            wait_cnt <= wait_cnt - SC_W'(1);
            if (wait_cnt == SC_W'(1)) begin
                active <= shadow;
            end
        end
    end
endmodule

// File: rtl/keywdt_divider.sv
// Tick divider: emits one tick every 2^(MIN_LOG2 + min(code, TOP_CODE))
// running cycles. Holds while run is low; restart clears the phase.
module keywdt_divider #(
    parameter int PRE_W    = 3,
    parameter int MIN_LOG2 = 2,
    parameter int TOP_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int DIV_W = MIN_LOG2 + TOP_CODE;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] limit;
    int               sel;

    // Saturate the code and form the terminal phase value.
    always_comb begin
        sel   = (int'(code) > TOP_CODE) ? TOP_CODE : int'(code);
        limit = DIV_W'((1 << (MIN_LOG2 + sel)) - 1);
        tick  = run && (phase >= limit);
    end

    // Advance the phase while running; wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + DIV_W'(1);
        end
    end
endmodule

// File: rtl/keywdt_counter.sv
// Down-counter: starts from all ones, reloads on refresh, and on a tick at
// zero raises a one-cycle pulse and restarts from all ones. Never stops
// once running, except through rst_n.
module keywdt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refresh,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    // Run state, count and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            count   <= ALL_ONES;
            pulse   <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (start && !running) begin
                running <= 1'b1;
                count   <= ALL_ONES;
            end else if (running && refresh) begin
                count <= reload_val;
            end else if (running && tick) begin
                if (count == '0) begin
                    pulse <= 1'b1;
                    count <= ALL_ONES;
                end else begin
                    count <= count - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/keywdt_top.sv
// Keyed independent watchdog: key decoder, two configuration update stages
// (prescaler, reload), tick divider and down-counter. Single clock domain;
// bus writes arrive as one-cycle strobes synchronous to clk.
module keywdt_top
    import keywdt_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int SYNC_CYCLES  = 3,
    parameter int PRE_W        = 3,
    parameter int PRE_MIN_LOG2 = 2,
    parameter int PRE_TOP_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [KEY_W-1:0] rd_data,
    input  logic             dbg_halt,
    input  logic             halt_stop_en,
    output logic             wdt_rst
);
    localparam logic [CNT_W-1:0] RLD_RESET = '1;
    localparam logic [PRE_W-1:0] PRE_RESET = '0;

    logic             start_req, refresh_req, cfg_open;
    logic             presc_load, reload_load;
    logic [PRE_W-1:0] presc_shadow, presc_active;
    logic [CNT_W-1:0] rld_shadow, rld_active;
    logic             presc_busy, rld_busy;
    logic             running, tick, div_restart, div_run;
    logic [CNT_W-1:0] count_q;

    keywdt_keyctl u_keyctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .start_req   (start_req),
        .refresh_req (refresh_req),
        .cfg_open    (cfg_open),
        .presc_load  (presc_load),
        .reload_load (reload_load)
    );

    keywdt_cfgsync #(.W(PRE_W), .SYNC_CYCLES(SYNC_CYCLES), .RESET_VAL(PRE_RESET)) u_presc_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (presc_load),
        .din    (wr_data[PRE_W-1:0]),
        .shadow (presc_shadow),
        .active (presc_active),
        .busy   (presc_busy)
    );

    keywdt_cfgsync #(.W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES), .RESET_VAL(RLD_RESET)) u_reload_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (reload_load),
        .din    (wr_data[CNT_W-1:0]),
        .shadow (rld_shadow),
        .active (rld_active),
        .busy   (rld_busy)
    );

    // Divider restarts with the counter; it holds when frozen by debug.
    always_comb begin
        div_restart = (start_req && !running) || (refresh_req && running);
        div_run     = running && !(dbg_halt && halt_stop_en);
    end

    keywdt_divider #(.PRE_W(PRE_W), .MIN_LOG2(PRE_MIN_LOG2), .TOP_CODE(PRE_TOP_CODE)) u_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .run     (div_run),
        .code    (presc_active),
        .tick    (tick)
    );

    keywdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_req),
        .refresh    (refresh_req),
        .tick       (tick),
        .reload_val (rld_active),
        .running    (running),
        .count      (count_q),
        .pulse      (wdt_rst)
    );

    // Register read mux.
    always_comb begin
        case (rd_addr)
            REG_PRESC:  rd_data = KEY_W'(presc_shadow);
            REG_RELOAD: rd_data = KEY_W'(rld_shadow);
            REG_STATUS: rd_data = KEY_W'({rld_busy, presc_busy});
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/keywdt_checker.sv
// Checker for keywdt_top: protocol and state properties, attached by bind.
module keywdt_checker
    import keywdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [KEY_W-1:0] wr_data,
    input logic             dbg_halt,
    input logic             halt_stop_en,
    input logic             wdt_rst,
    input logic             running,
    input logic [CNT_W-1:0] count_q,
    input logic             cfg_open,
    input logic             presc_busy,
    input logic             rld_busy,
    input logic [CNT_W-1:0] rld_shadow,
    input logic [CNT_W-1:0] rld_active
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic key_wr;
    always_comb key_wr = wr_en && (wr_addr == REG_KEY);

    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> running); // R1
    AST_START_LOADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_START && !running) |=> (running && count_q == ALL_ONES)); // R2
    AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_REFRESH && running) |=> (count_q == $past(rld_active))); // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !wdt_rst); // R5
    AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> (count_q == ALL_ONES)); // R5
    AST_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n) running |=> running); // R6
    AST_LOCKED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_RELOAD && !cfg_open) |=> $stable(rld_shadow)); // R7
    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data != KEY_UNLOCK) |=> !cfg_open); // R8
    AST_PRESC_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_PRESC && cfg_open) |=> presc_busy); // R9
    AST_RELOAD_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_RELOAD && cfg_open) |=> rld_busy); // R9
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbg_halt && halt_stop_en && !wr_en) |=> $stable(count_q)); // R10
endmodule

bind keywdt_top keywdt_checker #(.CNT_W(CNT_W)) u_keywdt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .dbg_halt     (dbg_halt),
    .halt_stop_en (halt_stop_en),
    .wdt_rst      (wdt_rst),
    .running      (running),
    .count_q      (count_q),
    .cfg_open     (cfg_open),
    .presc_busy   (presc_busy),
    .rld_busy     (rld_busy),
    .rld_shadow   (rld_shadow),
    .rld_active   (rld_active)
);

// File: tb/keywdt_top_bench.sv
// Bench: 6-bit counter, 3-cycle update stage; sweeps prescaler codes and
// reload values and measures pulse distances against (R+1)*D.
module keywdt_top_bench;
    localparam int CW   = 6;
    localparam int FULL = 1 << CW;
    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        halt_stop_en = 1'b0;
    logic        wdt_rst;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keywdt_top #(.CNT_W(CW), .SYNC_CYCLES(SYNC)) u_keywdt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
        .halt_stop_en(halt_stop_en), .wdt_rst(wdt_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; dbg_halt = 1'b0; halt_stop_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One write, driven at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_pulse(input int limit, output int t);
        bit seen = 1'b0;
        t = -1;
        for (int i = 0; i < limit && !seen; i++) begin
            if (wdt_rst) begin
                t = cyc;
                seen = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic configure(input int code, input int rv);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rv));
        repeat (SYNC + 1) @(negedge clk);
    endtask

    function automatic int div_of(input int code);
        return 1 << (2 + ((code > 6) ? 6 : code));
    endfunction

    initial begin
        #(190000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, t0, t1, t2;
        // R1: reset state
        do_reset();
        rd(2'd1, v); check(v == 0, "R1 prescaler reset", v, 0);
        rd(2'd2, v); check(v == FULL - 1, "R1 reload reset", v, FULL - 1);
        rd(2'd3, v); check(v == 0, "R1 status reset", v, 0);
        wait_pulse(300, t1); check(t1 == -1, "R1 idle no pulse", t1, -1);
        // R4: refresh while idle has no effect
        wr(2'd0, 16'hAAAA);
        wait_pulse(400, t1); check(t1 == -1, "R4 refresh idle", t1, -1);

        // R3, R2: all prescaler codes from start
        for (int c = 0; c < 8; c++) begin
            do_reset();
            if (c != 0) configure(c, FULL - 1);
            wr(2'd0, 16'hCCCC); t0 = cyc;
            wait_pulse(FULL * 256 + 50, t1);
            check(t1 - t0 == FULL * div_of(c), "R3 divider code", t1 - t0, FULL * div_of(c));
        end

        // R4: every reload value
        for (int r = 0; r < FULL; r++) begin
            do_reset();
            configure(0, r);
            wr(2'd0, 16'hCCCC);
            repeat (5) @(negedge clk);
            wr(2'd0, 16'hAAAA); t0 = cyc;
            wait_pulse(FULL * 4 + 50, t1);
            check(t1 - t0 == (r + 1) * 4, "R4 reload distance", t1 - t0, (r + 1) * 4);
        end

        // R5: single-cycle pulse and repeat period
        do_reset();
        wr(2'd0, 16'hCCCC); t0 = cyc;
        wait_pulse(FULL * 4 + 50, t1);
        check(t1 - t0 == FULL * 4, "R5 first pulse", t1 - t0, FULL * 4);
        @(negedge clk);
        check(wdt_rst == 1'b0, "R5 pulse width", int'(wdt_rst), 0);
        wait_pulse(FULL * 4 + 50, t2);
        check(t2 - t1 == FULL * 4, "R5 repeat period", t2 - t1, FULL * 4);

        // R2, R6: repeated start and stray keys do not change timing
        do_reset();
        wr(2'd0, 16'hCCCC); t0 = cyc;
        repeat (30) @(negedge clk);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wait_pulse(FULL * 4 + 50, t1);
        check(t1 - t0 == FULL * 4, "R2 R6 start while running", t1 - t0, FULL * 4);
        // R6: only rst_n stops it
        wr(2'd0, 16'hAAAA);
        repeat (20) @(negedge clk);
        do_reset();
        wait_pulse(FULL * 4 + 100, t1);
        check(t1 == -1, "R6 reset stops", t1, -1);

        // R7: locked writes ignored
        do_reset();
        wr(2'd2, 16'd5);
        rd(2'd2, v); check(v == FULL - 1, "R7 locked reload", v, FULL - 1);
        wr(2'd1, 16'd3);
        rd(2'd1, v); check(v == 0, "R7 locked prescaler", v, 0);
        rd(2'd3, v); check(v == 0, "R7 locked no busy", v, 0);
        wr(2'd0, 16'hCCCC);
        wr(2'd2, 16'd9);
        repeat (SYNC + 2) @(negedge clk);
        wr(2'd0, 16'hAAAA); t0 = cyc;
        wait_pulse(FULL * 4 + 50, t1);
        check(t1 - t0 == FULL * 4, "R7 locked reload timing", t1 - t0, FULL * 4);

        // R8: refresh key relocks; config writes do not
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'd5);
        rd(2'd2, v); check(v == FULL - 1, "R8 relock by refresh", v, FULL - 1);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd5);
        rd(2'd2, v); check(v == 5, "R8 stays open reload", v, 5);
        rd(2'd1, v); check(v == 2, "R8 stays open prescaler", v, 2);

        // R9: busy flag duration and pending value
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        for (int i = 0; i < SYNC; i++) begin
            rd(2'd3, v); check(v == 1, "R9 prescaler busy", v, 1);
            @(negedge clk);
        end
        rd(2'd3, v); check(v == 0, "R9 prescaler busy clear", v, 0);
        do_reset();
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd10);
        rd(2'd3, v); check(v == 2, "R9 reload busy", v, 2);
        wr(2'd0, 16'hAAAA); t0 = cyc;
        wait_pulse(FULL * 4 + 50, t1);
        check(t1 - t0 == FULL * 4, "R9 pending not used", t1 - t0, FULL * 4);
        wr(2'd0, 16'hAAAA); t0 = cyc;
        wait_pulse(FULL * 4 + 50, t1);
        check(t1 - t0 == 11 * 4, "R9 committed used", t1 - t0, 44);

        // R10: freeze with stop enabled, none without
        do_reset();
        halt_stop_en = 1'b1;
        wr(2'd0, 16'hCCCC); t0 = cyc;
        repeat (20) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (37) @(negedge clk);
        dbg_halt = 1'b0;
        wait_pulse(FULL * 4 + 100, t1);
        check(t1 - t0 == FULL * 4 + 37, "R10 frozen", t1 - t0, FULL * 4 + 37);
        do_reset();
        wr(2'd0, 16'hCCCC); t0 = cyc;
        repeat (20) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (37) @(negedge clk);
        dbg_halt = 1'b0;
        wait_pulse(FULL * 4 + 100, t1);
        check(t1 - t0 == FULL * 4, "R10 not frozen", t1 - t0, FULL * 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule